// File: doc/BRIEF.md
# VGA Attribute Pixel Mapper

This block sits between the sequencer's pixel stream and the colour DAC. Each accepted pixel carries a 4-bit foreground code, the background nibble of its character attribute and a font bit. The block picks one 4-bit code from these according to the display mode and the blink state. It then maps that code to an 8-bit video word in one of two ways. In the sixteen-colour modes it looks the code up in a bank of sixteen 6-bit palette registers. In the pass-through mode it joins two successive codes into one byte.

A two-state index/data write port loads the sixteen palette entries, a mode register, a color select register and a blink-rate register. A read port shows the register that the current index selects. A vertical sync input is divided down to make the blink phase used for text cells and for graphics.

Both pixel interfaces are valid/ready. A pixel is taken on a cycle where `in_valid` and `in_ready` are both high. A word leaves on a cycle where `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure from the DAC side stalls the sequencer with no loss of data. While `out_valid` is high and `out_ready` is low, `out_data` does not change.

Top module: `attr_pixmap`

## Requirements
- R1: The write port alternates between two states. In the index state, a `reg_wr` pulse loads `reg_wdata[4:0]` as the index. In the data state, a `reg_wr` pulse stores `reg_wdata` into the indexed register and returns the port to the index state. `port_rst` (and reset) forces the index state and overrides a coincident `reg_wr`.
- R2: `rd_data` shows the register at the current index, zero-extended to 8 bits. The indices are:
  - 00h–0Fh: palette entries, 6 bits each.
  - 10h: mode register. Bit 4 is reserved: it always reads 0, and writing it has no effect.
  - 11h: color select, 4 bits.
  - 12h: blink rate, 8 bits.
  - Every other index reads 0.
- R3: In sixteen-colour mode (mode bit 6 = 0) with mode bit 7 = 0, an accepted code c yields, on the next cycle, `out_data` = {cs[3:2], pal[c][5:4], pal[c][3:0]}.
- R4: With mode bit 7 = 1 in sixteen-colour mode, output bits 5:4 come from cs[1:0] for every code. All other output bits are as in R3.
- R5: With mode bit 6 = 1 the palette is bypassed. Every two accepted codes a, b produce a single word {a, b} on the cycle after b is accepted. No word is produced after a alone. Leaving this mode discards a half-formed pair.
- R6: In text mode (mode bit 0 = 0) with blinking off (mode bit 3 = 0), the selected code is the foreground code when the font bit is 1. Otherwise it is the full 4-bit background nibble.
- R7: In text mode with blinking on, the background code is {0, bg[2:0]} and bg[3] is the blink flag. A cell with the flag set shows the background code during the off phase, whatever its font bit.
- R8: In graphics mode (mode bit 0 = 1) with blinking on, bit 3 of the code is forced to 0 during the off phase. With blinking off, the code passes unchanged.
- R9: The blink phase starts in the on phase after reset. It toggles on every (rate+1)-th rising edge of `vsync`, and the count restarts at each toggle.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R11: After reset the block is in the following state:
  - `out_valid` is 0 and `in_ready` is 1.
  - All registers are 0.
  - The port is in the index state and the pair joiner is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe of the index/data port |
| reg_wdata | input | 8 | Index or data written |
| port_rst | input | 1 | Returns the write port to the index state |
| rd_data | output | 8 | Register selected by the current index |
| vsync | input | 1 | Vertical sync used to time blinking |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_code | input | 4 | Foreground or graphics pixel code |
| in_bg | input | 4 | Background attribute nibble (bit 3 blink flag or intensity) |
| in_glyph | input | 1 | Font bit: 1 selects the foreground in text mode |
| out_valid | output | 1 | Video word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 8 | Video word to the DAC |

## Verification
A corrupted palette entry or color select field changes the next word mapped through that code, one cycle after the pixel is accepted. A loop over all palette entries with random codes therefore exposes it within a few pixels. A port stuck in the wrong index/data state puts a value into the wrong register, and the first read-back or mapped pixel shows it. A blink counter off by one flips which cells are hidden one `vsync` edge early or late, and the cell checked directly after each pulse shows it. A pair joiner out of step produces a word after the first code of a pair instead of the second.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int CODE_W = 4;
  localparam int NCOL   = 1 << CODE_W;
  localparam int PAL_W  = 6;
  localparam int OUT_W  = 2 * CODE_W;
  localparam int IDX_W  = 5;
  localparam int CS_W   = 4;
  localparam logic [IDX_W-1:0] IDX_MODE = 5'h10;
  localparam logic [IDX_W-1:0] IDX_CSEL = 5'h11;
  localparam logic [IDX_W-1:0] IDX_RATE = 5'h12;
  localparam logic [7:0] MODE_RSVD_MASK = 8'h10;
  typedef logic [PAL_W-1:0]  pal_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/attr_regs.sv
module attr_regs
  import attr_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              port_rst,
  output logic [7:0]        rd_data,
  output logic [IDX_W-1:0]  idx_q,
  output logic              data_ph,
  output pal_t              pal [NCOL],
  output logic              m_gfx,
  output logic              m_blink,
  output logic              m_pass8,
  output logic              m_p54cs,
  output logic [CS_W-1:0]   cs_q,
  output logic [RATE_W-1:0] rate_q
);
  logic [7:0] mode_q;
  logic       wr_data;

  assign wr_data = reg_wr && data_ph && !port_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      data_ph <= 1'b0;
    end else if (port_rst) begin
      data_ph <= 1'b0;
    end else if (reg_wr) begin
      if (!data_ph) idx_q <= reg_wdata[IDX_W-1:0];
      data_ph <= !data_ph;
    end
  end

  generate
    for (genvar g = 0; g < NCOL; g++) begin : g_pal
      always_ff @(posedge clk) begin
        if (!rst_n)
          pal[g] <= '0;
        else if (wr_data && idx_q == IDX_W'(g))
          pal[g] <= reg_wdata[PAL_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cs_q   <= '0;
      rate_q <= '0;
    end else if (wr_data) begin
      case (idx_q)
        IDX_MODE: mode_q <= reg_wdata & ~MODE_RSVD_MASK;
        IDX_CSEL: cs_q   <= reg_wdata[CS_W-1:0];
        IDX_RATE: rate_q <= reg_wdata[RATE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (idx_q < IDX_W'(NCOL))
      rd_data = 8'(pal[idx_q[CODE_W-1:0]]);
    else begin
      case (idx_q)
        IDX_MODE: rd_data = mode_q;
        IDX_CSEL: rd_data = 8'(cs_q);
        IDX_RATE: rd_data = 8'(rate_q);
        default:  rd_data = '0;
      endcase
    end
  end

  assign m_gfx   = mode_q[0];
  assign m_blink = mode_q[3];
  assign m_pass8 = mode_q[6];
  assign m_p54cs = mode_q[7];
endmodule

// File: rtl/attr_blink.sv
module attr_blink #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic [RATE_W-1:0] rate,
  output logic              blink_off
);
  logic              vs_d;
  logic [RATE_W-1:0] cnt;
  logic              vs_rise;

  assign vs_rise = vsync && !vs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d      <= 1'b0;
      cnt       <= '0;
      blink_off <= 1'b0;
    end else begin
      vs_d <= vsync;
      if (vs_rise) begin
        if (cnt >= rate) begin
          cnt       <= '0;
          blink_off <= !blink_off;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/attr_pixpipe.sv
module attr_pixpipe
  import attr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_gfx,
  input  logic            m_blink,
  input  logic            m_pass8,
  input  logic            m_p54cs,
  input  logic [CS_W-1:0] cs,
  input  pal_t            pal [NCOL],
  input  logic            blink_off,
  input  logic            in_valid,
  output logic            in_ready,
  input  code_t           in_code,
  input  code_t           in_bg,
  input  logic            in_glyph,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic            half_full
);
  code_t      bg_code, sel_code, half_q;
  pal_t       entry;
  logic [1:0] upper2;
  logic [OUT_W-1:0] word16;
  logic       hide_fg, accept;

  always_comb begin
    bg_code = m_blink ? {1'b0, in_bg[CODE_W-2:0]} : in_bg;
    hide_fg = m_blink && in_bg[CODE_W-1] && blink_off;
    if (!m_gfx)
      sel_code = (in_glyph && !hide_fg) ? in_code : bg_code;
    else if (m_blink && blink_off)
      sel_code = {1'b0, in_code[CODE_W-2:0]};
    else
      sel_code = in_code;
  end

  assign entry  = pal[sel_code];
  assign upper2 = m_p54cs ? cs[1:0] : entry[5:4];
  assign word16 = {cs[3:2], upper2, entry[3:0]};

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      half_full <= 1'b0;
      half_q    <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!m_pass8) half_full <= 1'b0;
      if (accept) begin
        if (!m_pass8) begin
          out_valid <= 1'b1;
          out_data  <= word16;
        end else if (!half_full) begin
          half_q    <= sel_code;
          half_full <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= {half_q, sel_code};
          half_full <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/attr_pixmap.sv
module attr_pixmap
  import attr_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       port_rst,
  output logic [7:0] rd_data,
  input  logic       vsync,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [3:0] in_code,
  input  logic [3:0] in_bg,
  input  logic       in_glyph,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic [IDX_W-1:0]  idx_q;
  logic              data_ph;
  pal_t              pal [NCOL];
  logic              m_gfx, m_blink, m_pass8, m_p54cs;
  logic [CS_W-1:0]   cs_q;
  logic [RATE_W-1:0] rate_q;
  logic              blink_off, pair_half;

  attr_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .port_rst(port_rst), .rd_data(rd_data), .idx_q(idx_q), .data_ph(data_ph),
    .pal(pal), .m_gfx(m_gfx), .m_blink(m_blink), .m_pass8(m_pass8),
    .m_p54cs(m_p54cs), .cs_q(cs_q), .rate_q(rate_q)
  );

  attr_blink #(.RATE_W(RATE_W)) u_blink (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .rate(rate_q), .blink_off(blink_off)
  );

  attr_pixpipe u_pipe (
    .clk(clk), .rst_n(rst_n), .m_gfx(m_gfx), .m_blink(m_blink),
    .m_pass8(m_pass8), .m_p54cs(m_p54cs), .cs(cs_q), .pal(pal),
    .blink_off(blink_off), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_bg(in_bg), .in_glyph(in_glyph),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .half_full(pair_half)
  );
endmodule

// File: rtl/attr_pixmap_chk.sv
module attr_pixmap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       port_rst,
  input logic [7:0] rd_data,
  input logic       vsync,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [4:0] idx,
  input logic       is_data,
  input logic       m_pass8,
  input logic       half_full,
  input logic       phase
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !m_pass8 |=> out_valid); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idx == 5'h10 |-> !rd_data[4]); // R2

  AST_PORT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !port_rst |=> is_data != $past(is_data)); // R1

  AST_PORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |=> !is_data); // R1

  AST_BLINK_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(vsync)); // R9

  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(m_pass8) && $rose(out_valid) |-> $past(half_full)); // R5
endmodule

bind attr_pixmap attr_pixmap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .port_rst(port_rst),
  .rd_data(rd_data), .vsync(vsync), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .idx(idx_q), .is_data(data_ph), .m_pass8(m_pass8), .half_full(pair_half),
  .phase(blink_off)
);

// File: tb/tb_attr_pixmap.sv
`timescale 1ns/1ps
module tb_attr_pixmap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, port_rst = 1'b0, vsync = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic in_valid = 1'b0, in_ready, in_glyph = 1'b0;
  logic [3:0] in_code = '0, in_bg = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic [5:0] pal_m [16];
  logic [7:0] mode_m = '0;
  logic [3:0] cs_m = '0;
  logic [7:0] rate_m = '0, cnt_m = '0;
  logic phase_m = 1'b0;

  always #2 clk = ~clk;

  attr_pixmap dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .port_rst(port_rst), .rd_data(rd_data), .vsync(vsync),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .in_bg(in_bg), .in_glyph(in_glyph), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sel_m(logic [3:0] c, logic [3:0] bg, logic g);
    logic bl = mode_m[3];
    logic [3:0] bgc = bl ? {1'b0, bg[2:0]} : bg;
    if (!mode_m[0]) return (g && !(bl && bg[3] && phase_m)) ? c : bgc;
    if (bl && phase_m) return {1'b0, c[2:0]};
    return c;
  endfunction

  function automatic logic [7:0] map_m(logic [3:0] c);
    logic [1:0] up = mode_m[7] ? cs_m[1:0] : pal_m[c][5:4];
    return {cs_m[3:2], up, pal_m[c][3:0]};
  endfunction

  task automatic port_wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] i, input logic [7:0] v);
    port_wr({3'b0, i});
    port_wr(v);
    if (i < 16) pal_m[i] = v[5:0];
    else if (i == 5'h10) mode_m = v & 8'hEF;
    else if (i == 5'h11) cs_m = v[3:0];
    else if (i == 5'h12) rate_m = v;
  endtask

  task automatic pport_rst();
    @(negedge clk); port_rst = 1'b1;
    @(negedge clk); port_rst = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] i, input logic [7:0] exp, input string req);
    port_wr({3'b0, i});
    chk(rd_data == exp, req, rd_data, exp);
    pport_rst();
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] bg, input logic g);
    @(negedge clk); in_valid = 1'b1; in_code = c; in_bg = bg; in_glyph = g;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic px_chk(input logic [3:0] c, input logic [3:0] bg, input logic g, input string req);
    logic [7:0] e = map_m(sel_m(c, bg, g));
    send(c, bg, g);
    chk(out_valid && out_data == e, req, {out_valid, out_data}, {1'b1, e});
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    if (cnt_m >= rate_m) begin cnt_m = '0; phase_m = !phase_m; end
    else cnt_m = cnt_m + 1'b1;
  endtask

  initial begin
    int seed;
    seed = $urandom(20250611);
    for (int k = 0; k < 16; k++) pal_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!out_valid && in_ready, "R11 idle", {out_valid, in_ready}, 2'b01);
    chk(rd_data == 8'h00, "R11 regs zero", rd_data, 0);

    for (int k = 0; k < 16; k++) wr_reg(5'(k), 8'($urandom));
    rd_chk(5'd3, {2'b0, pal_m[3]}, "R2 palette 3");
    rd_chk(5'd15, {2'b0, pal_m[15]}, "R2 palette 15");
    wr_reg(5'h10, 8'hFF);
    rd_chk(5'h10, 8'hEF, "R2 reserved bit");
    rd_chk(5'h1F, 8'h00, "R2 unused index");
    wr_reg(5'h11, 8'hFA);
    rd_chk(5'h11, 8'h0A, "R2 color select");

    // R1: index set, then port reset, next write must be an index again
    port_wr(8'h11);
    pport_rst();
    wr_reg(5'h12, 8'h01);
    rd_chk(5'h11, 8'h0A, "R1 port reset kept csel");
    rd_chk(5'h12, 8'h01, "R1 rate stored");

    wr_reg(5'h10, 8'h01);
    for (int k = 0; k < 24; k++) px_chk(4'($urandom), 4'($urandom), 1'b1, "R3 palette map");
    wr_reg(5'h11, 8'h06);
    for (int k = 0; k < 16; k++) px_chk(4'(k), 4'h0, 1'b0, "R3 all codes");

    wr_reg(5'h10, 8'h81);
    for (int k = 0; k < 16; k++) px_chk(4'($urandom), 4'h0, 1'b0, "R4 shared bits");

    // R5 pass-through pairs
    wr_reg(5'h10, 8'h41);
    for (int k = 0; k < 8; k++) begin
      logic [3:0] a = 4'($urandom), b = 4'($urandom);
      send(a, 4'h0, 1'b0);
      chk(!out_valid, "R5 no word after first", out_valid, 0);
      send(b, 4'h0, 1'b0);
      chk(out_valid && out_data == {a, b}, "R5 joined", {out_valid, out_data}, {1'b1, a, b});
    end
    send(4'h9, 4'h0, 1'b0);
    wr_reg(5'h10, 8'h01);
    wr_reg(5'h10, 8'h41);
    send(4'h3, 4'h0, 1'b0);
    chk(!out_valid, "R5 half pair dropped", out_valid, 0);
    send(4'h5, 4'h0, 1'b0);
    chk(out_data == 8'h35, "R5 fresh pair", out_data, 8'h35);

    // R6 text, blinking off
    wr_reg(5'h10, 8'h00);
    for (int k = 0; k < 20; k++) px_chk(4'($urandom), 4'($urandom), 1'($urandom), "R6 text select");
    px_chk(4'h2, 4'hC, 1'b0, "R6 intensity bg");

    // R7 text blink, on phase then off phase
    wr_reg(5'h10, 8'h08);
    for (int k = 0; k < 12; k++) px_chk(4'($urandom), 4'($urandom), 1'($urandom), "R7 blink on phase");
    vs_pulse(); vs_pulse();
    chk(phase_m == 1'b1, "R9 model", phase_m, 1);
    px_chk(4'h7, 4'hA, 1'b1, "R7 hidden cell");
    px_chk(4'h7, 4'h2, 1'b1, "R7 steady cell");
    for (int k = 0; k < 12; k++) px_chk(4'($urandom), 4'($urandom), 1'($urandom), "R7 blink off phase");

    // R8 graphics blink
    wr_reg(5'h10, 8'h09);
    for (int k = 0; k < 12; k++) px_chk(4'($urandom), 4'h0, 1'b0, "R8 graphics blink");
    wr_reg(5'h10, 8'h01);
    px_chk(4'hE, 4'h0, 1'b0, "R8 blink disabled");

    // R9 divide: rate 2 toggles on the third edge
    wr_reg(5'h12, 8'h02);
    wr_reg(5'h10, 8'h08);
    vs_pulse(); vs_pulse();
    px_chk(4'h7, 4'hA, 1'b1, "R9 held after two edges");
    vs_pulse();
    px_chk(4'h7, 4'hA, 1'b1, "R9 toggled on third edge");

    // R10 back-pressure
    wr_reg(5'h10, 8'h01);
    out_ready = 1'b0;
    send(4'h4, 4'h0, 1'b0);
    @(negedge clk); in_valid = 1'b1; in_code = 4'hB;
    chk(!in_ready, "R10 stalled ready", in_ready, 0);
    @(negedge clk);
    chk(out_valid && out_data == map_m(4'h4), "R10 held word", out_data, map_m(4'h4));
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid && out_data == map_m(4'hB), "R10 released", out_data, map_m(4'hB));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule